// File: doc/BRIEF.md
# CPU Condition-Code Flag Generator

This block computes and holds the eight-bit condition code register of a small accumulator CPU. Each cycle the datapath may present an operation class, a byte-or-word width select, both operands, the result it produced and, for shifts, the carry that the shift pushed out. From these the block derives the negative, zero, overflow and carry flags. It derives carry and overflow from sign-bit equations on the operands and the result, not from an adder carry-out. The four control flags (stop-disable, interrupt masks, half carry) are left alone by arithmetic updates.

Two other ways to change the register sit beside the arithmetic path. A whole-register load replaces all eight bits. A single-flag port sets or clears one chosen bit and leaves the other seven as they were. When more than one request arrives in the same cycle, the whole load wins, then the single-flag port, then the arithmetic update. The register changes on the rising clock edge after the request and holds its value when nothing is requested.

The register layout from bit 7 down to bit 0 is S, X, H, I, N, Z, V, C. The update is a three-way choice: LOAD (whole write), POKE (single flag), EVAL (arithmetic update), with HOLD when none is active.

Top module: `ccr_flag_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request, `ccr` reads 0xD0, which has S (bit 7), X (bit 6) and I (bit 4) set and every other bit clear.
- R2: For an add (`upd_op` = 1), C is set when at the sign bit at least two of {a, b, NOT r} are 1. V is set when a and b share a sign and r has the other sign. N copies the result sign bit, and Z is set when the result is all zeros.
- R3: For a subtract (`upd_op` = 2), C (borrow) is the sign bit of (NOT a AND b) OR (b AND r) OR (NOT a AND r). V is set when a and b differ in sign and r has the sign of b. N and Z are set as for an add.
- R4: For a test/load (`upd_op` = 3), V is cleared, N copies the result sign bit, Z is set on a zero result, and C keeps its previous value.
- R5: For a shift (`upd_op` = 4), C takes `shift_c`, N copies the result sign bit, Z is set on a zero result, and V becomes the new N xor the new C.
- R6: With `word_mode` = 0 the sign bit is bit 7 and Z looks only at bits 7..0, so bits 15..8 of the operands and the result have no effect. With `word_mode` = 1 the sign bit is bit 15 and Z looks at all 16 bits.
- R7: An arithmetic update never changes bits 7..4 (S, X, H, I).
- R8: `wr_en` loads `wr_data` into all eight bits on the next edge and overrides every other request in that cycle.
- R9: `flag_en` without `wr_en` writes `flag_val` into bit `flag_sel` and leaves the other seven bits unchanged, and it overrides an arithmetic update in the same cycle.
- R10: With no request active, or with `upd_op` = 0 or any code from 5 to 7, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Arithmetic update request |
| upd_op | input | 3 | Operation class: 0 none, 1 add, 2 subtract, 3 test/load, 4 shift |
| word_mode | input | 1 | 0 selects byte width, 1 selects word width |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| result | input | 16 | Result the datapath produced |
| shift_c | input | 1 | Carry produced by the shift in this cycle |
| wr_en | input | 1 | Whole-register load strobe |
| wr_data | input | 8 | Value for a whole-register load |
| flag_en | input | 1 | Single-flag write strobe |
| flag_sel | input | 3 | Bit index of the single flag |
| flag_val | input | 1 | Value written to the single flag |
| ccr | output | 8 | Condition code register |

## Verification
The assertions assume that the request inputs are known after reset. They also assume that the operation code, when an update is requested, is one of the listed classes or an unused code the block must ignore. The bench drives every request input to a defined value on each falling edge and never leaves one floating. It supplies results that agree with the operands (a true sum or difference at the chosen width), so a reference model built on plain integer arithmetic gives carry and overflow values that the sign-bit equations must reproduce. Byte-mode vectors deliberately put noise in bits 15..8 so that the sign bit and zero detection are shown to come from the low byte only.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int CCR_W   = 8;
    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;

    localparam int BIT_C = 0;
    localparam int BIT_V = 1;
    localparam int BIT_Z = 2;
    localparam int BIT_N = 3;

    localparam logic [CCR_W-1:0] CCR_RESET = 8'hD0;

    typedef enum logic [2:0] {
        OPC_NONE  = 3'd0,
        OPC_ADD   = 3'd1,
        OPC_SUB   = 3'd2,
        OPC_TEST  = 3'd3,
        OPC_SHIFT = 3'd4
    } op_class_e;

    typedef enum logic [1:0] {
        SEL_HOLD = 2'd0,
        SEL_EVAL = 2'd1,
        SEL_POKE = 2'd2,
        SEL_LOAD = 2'd3
    } upd_src_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
        logic keep_c;
        logic valid;
    } flag_set_t;

endpackage

// File: rtl/ccr_flag_eval.sv
module ccr_flag_eval
    import ccr_pkg::*;
#(
    parameter int DATA_W   = WORD_W,
    parameter int NARROW_W = BYTE_W
) (
    input  logic [2:0]        op,
    input  logic              word_mode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] r,
    input  logic              shift_c,
    output flag_set_t         flags
);

    localparam int NUM_W = 2;

    flag_set_t per_w [NUM_W];

    for (genvar gi = 0; gi < NUM_W; gi++) begin : g_width
        localparam int W   = (gi == 1) ? DATA_W : NARROW_W;
        localparam int MSB = W - 1;

        logic am, bm, rm, zero;
        op_class_e opc;

        assign am   = a[MSB];
        assign bm   = b[MSB];
        assign rm   = r[MSB];
        assign zero = (r[MSB:0] == '0);
        assign opc  = op_class_e'(op);

        always_comb begin
            per_w[gi]        = '0;
            per_w[gi].n      = rm;
            per_w[gi].z      = zero;
            per_w[gi].keep_c = 1'b0;
            per_w[gi].valid  = 1'b1;
            unique case (opc)
                OPC_ADD: begin
                    per_w[gi].c = (am & bm) | (bm & ~rm) | (am & ~rm);
                    per_w[gi].v = (am & bm & ~rm) | (~am & ~bm & rm);
                end
                OPC_SUB: begin
                    per_w[gi].c = (~am & bm) | (bm & rm) | (~am & rm);
                    per_w[gi].v = (am & ~bm & ~rm) | (~am & bm & rm);
                end
                OPC_TEST: begin
                    per_w[gi].v      = 1'b0;
                    per_w[gi].keep_c = 1'b1;
                end
                OPC_SHIFT: begin
                    per_w[gi].c = shift_c;
                    per_w[gi].v = rm ^ shift_c;
                end
                default: begin
                    per_w[gi].valid = 1'b0;
                end
            endcase
        end
    end

    assign flags = word_mode ? per_w[1] : per_w[0];

endmodule

// File: rtl/ccr_next_sel.sv
module ccr_next_sel
    import ccr_pkg::*;
#(
    parameter int REG_W = CCR_W
) (
    input  logic [REG_W-1:0]         cur,
    input  logic                     upd_en,
    input  flag_set_t                flags,
    input  logic                     wr_en,
    input  logic [REG_W-1:0]         wr_data,
    input  logic                     flag_en,
    input  logic [$clog2(REG_W)-1:0] flag_sel,
    input  logic                     flag_val,
    output logic [REG_W-1:0]         nxt
);

    upd_src_e src;

    always_comb begin
        if (wr_en)
            src = SEL_LOAD;
        else if (flag_en)
            src = SEL_POKE;
        else if (upd_en && flags.valid)
            src = SEL_EVAL;
        else
            src = SEL_HOLD;
    end

    always_comb begin
        nxt = cur;
        unique case (src)
            SEL_LOAD: nxt = wr_data;
            SEL_POKE: begin
                nxt           = cur;
                nxt[flag_sel] = flag_val;
            end
            SEL_EVAL: begin
                nxt[BIT_N] = flags.n;
                nxt[BIT_Z] = flags.z;
                nxt[BIT_V] = flags.v;
                nxt[BIT_C] = flags.keep_c ? cur[BIT_C] : flags.c;
            end
            SEL_HOLD: nxt = cur;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
    import ccr_pkg::*;
#(
    parameter int DATA_W   = WORD_W,
    parameter int NARROW_W = BYTE_W,
    parameter int REG_W    = CCR_W,
    localparam int SEL_W   = $clog2(REG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [2:0]        upd_op,
    input  logic              word_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] result,
    input  logic              shift_c,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              flag_en,
    input  logic [SEL_W-1:0]  flag_sel,
    input  logic              flag_val,
    output logic [REG_W-1:0]  ccr
);

    flag_set_t        flags;
    logic [REG_W-1:0] ccr_q;
    logic [REG_W-1:0] ccr_d;

    ccr_flag_eval #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_eval (
        .op        (upd_op),
        .word_mode (word_mode),
        .a         (opnd_a),
        .b         (opnd_b),
        .r         (result),
        .shift_c   (shift_c),
        .flags     (flags)
    );

    ccr_next_sel #(
        .REG_W (REG_W)
    ) u_sel (
        .cur      (ccr_q),
        .upd_en   (upd_en),
        .flags    (flags),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .flag_en  (flag_en),
        .flag_sel (flag_sel),
        .flag_val (flag_val),
        .nxt      (ccr_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            ccr_q <= CCR_RESET[REG_W-1:0];
        else
            ccr_q <= ccr_d;
    end

    assign ccr = ccr_q;

endmodule

// File: rtl/ccr_flag_chk.sv
module ccr_flag_chk
    import ccr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       upd_en,
    input logic [2:0] upd_op,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       flag_en,
    input logic [2:0] flag_sel,
    input logic [7:0] ccr
);

    logic arith;
    logic quiet;
    assign arith = upd_en && !wr_en && !flag_en;
    assign quiet = !wr_en && !flag_en && (!upd_en || upd_op == 3'd0 || upd_op > 3'd4);

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        arith |=> ccr[7:4] == $past(ccr[7:4])); // R7

    AST_TEST_CLEARS_V: assert property (@(posedge clk) disable iff (!rst_n)
        (arith && upd_op == 3'd3) |=> !ccr[BIT_V]); // R4

    AST_TEST_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (arith && upd_op == 3'd3) |=> ccr[BIT_C] == $past(ccr[BIT_C])); // R4

    AST_SHIFT_V_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (arith && upd_op == 3'd4) |=> ccr[BIT_V] == (ccr[BIT_N] ^ ccr[BIT_C])); // R5

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ccr == $past(wr_data)); // R8

    AST_POKE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && !wr_en) |=> ((ccr ^ $past(ccr)) & ~(8'h01 << $past(flag_sel))) == 8'h00); // R9

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> $stable(ccr)); // R10

endmodule

bind ccr_flag_unit ccr_flag_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (upd_en),
    .upd_op   (upd_op),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .flag_en  (flag_en),
    .flag_sel (flag_sel),
    .ccr      (ccr)
);

// File: tb/tb_ccr_flag_unit.sv
`timescale 1ns/1ps
module tb_ccr_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [2:0]  upd_op = 3'd0;
    logic        word_mode = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0, result = '0;
    logic        shift_c = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        flag_en = 1'b0;
    logic [2:0]  flag_sel = '0;
    logic        flag_val = 1'b0;
    logic [7:0]  ccr;

    always #5 clk = ~clk;

    ccr_flag_unit dut (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_op(upd_op),
        .word_mode(word_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .shift_c(shift_c), .wr_en(wr_en), .wr_data(wr_data),
        .flag_en(flag_en), .flag_sel(flag_sel), .flag_val(flag_val), .ccr(ccr)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t      sb_q[$];
    int         n_vec = 0;
    int         n_bad = 0;
    logic [7:0] mdl = 8'hD0;
    bit         done = 1'b0;

    // Reference model written from the requirements with integer arithmetic.
    function automatic logic [7:0] ref_next(
        input logic [7:0] cur, input logic ue, input logic [2:0] op,
        input logic wd, input logic [15:0] a, input logic [15:0] b,
        input logic [15:0] r, input logic sc, input logic we,
        input logic [7:0] wdat, input logic fe, input logic [2:0] fs,
        input logic fv);
        logic [7:0]  nx;
        logic [15:0] m, aa, bb, rr;
        logic [16:0] s;
        logic        sa, sb, sr, n, z, v, c;
        int          top;
        nx  = cur;
        top = wd ? 15 : 7;
        m   = wd ? 16'hFFFF : 16'h00FF;
        aa = a & m; bb = b & m; rr = r & m;
        sa = aa[top]; sb = bb[top]; sr = rr[top];
        n = sr; z = (rr == 16'h0000);
        if (we) return wdat;
        if (fe) begin
            nx[fs] = fv;
            return nx;
        end
        if (!ue) return cur;
        case (op)
            3'd1: begin
                s = {1'b0, aa} + {1'b0, bb};
                c = wd ? s[16] : s[8];
                v = (sa == sb) && (sr != sa);
                nx[3:0] = {n, z, v, c};
            end
            3'd2: begin
                c = (aa < bb);
                v = (sa != sb) && (sr != sa);
                nx[3:0] = {n, z, v, c};
            end
            3'd3: nx[3:0] = {n, z, 1'b0, cur[0]};
            3'd4: nx[3:0] = {n, z, n ^ sc, sc};
            default: nx = cur;
        endcase
        return nx;
    endfunction

    task automatic drive(
        input logic ue, input logic [2:0] op, input logic wd,
        input logic [15:0] a, input logic [15:0] b, input logic [15:0] r,
        input logic sc, input logic we, input logic [7:0] wdat,
        input logic fe, input logic [2:0] fs, input logic fv, input string tag);
        item_t it;
        @(negedge clk);
        upd_en = ue; upd_op = op; word_mode = wd;
        opnd_a = a; opnd_b = b; result = r; shift_c = sc;
        wr_en = we; wr_data = wdat; flag_en = fe; flag_sel = fs; flag_val = fv;
        mdl = ref_next(mdl, ue, op, wd, a, b, r, sc, we, wdat, fe, fs, fv);
        @(posedge clk);
        #1;
        it.exp = mdl;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic arith(input logic [2:0] op, input logic wd,
        input logic [15:0] a, input logic [15:0] b, input logic [15:0] r,
        input logic sc, input string tag);
        drive(1'b1, op, wd, a, b, r, sc, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, tag);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, tag);
    endtask

    // Monitor: compare each produced register value against the queue head.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_vec++;
            if (ccr !== it.exp) begin
                n_bad++;
                $display("FAIL %s: ccr=%02h expected=%02h", it.tag, ccr, it.exp);
            end
        end
    end

    initial begin
        fork
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    n_bad++;
                    $display("FAIL watchdog: actual=timeout expected=completion");
                    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                    $finish;
                end
            end
        join_none

        repeat (3) @(negedge clk);
        n_vec++;
        if (ccr !== 8'hD0) begin
            n_bad++;
            $display("FAIL R1 in reset: ccr=%02h expected=d0", ccr);
        end
        rst_n = 1'b1;
        idle("R1 after release");

        // R2 add, byte
        arith(3'd1, 1'b0, 16'h007F, 16'h0001, 16'h0080, 1'b0, "R2 byte add signed overflow");
        arith(3'd1, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b0, "R2 byte add carry and zero");
        arith(3'd1, 1'b0, 16'h0010, 16'h0020, 16'h0030, 1'b0, "R2 byte add plain");
        arith(3'd1, 1'b0, 16'h0080, 16'h0080, 16'h0000, 1'b0, "R2 byte add neg overflow");
        // R2 add, word
        arith(3'd1, 1'b1, 16'hFFFF, 16'h0001, 16'h0000, 1'b0, "R2 word add carry");
        arith(3'd1, 1'b1, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, "R2 word add overflow");
        // R3 subtract
        arith(3'd2, 1'b0, 16'h0000, 16'h0001, 16'h00FF, 1'b0, "R3 byte sub borrow");
        arith(3'd2, 1'b0, 16'h0080, 16'h0001, 16'h007F, 1'b0, "R3 byte sub overflow");
        arith(3'd2, 1'b1, 16'h1234, 16'h1234, 16'h0000, 1'b0, "R3 word sub equal");
        arith(3'd2, 1'b1, 16'h7FFF, 16'hFFFF, 16'h8000, 1'b0, "R3 word sub borrow overflow");
        // R4 test keeps C (C is 1 from previous vector)
        arith(3'd3, 1'b1, 16'h0, 16'h0, 16'h8001, 1'b0, "R4 test negative keeps C");
        arith(3'd3, 1'b1, 16'h0, 16'h0, 16'h0000, 1'b0, "R4 test zero");
        // R6 byte mode ignores upper bits
        arith(3'd3, 1'b0, 16'h0, 16'h0, 16'h1200, 1'b0, "R6 byte test upper noise zero");
        arith(3'd1, 1'b0, 16'hAA7F, 16'h5501, 16'hFF80, 1'b0, "R6 byte add upper noise");
        arith(3'd2, 1'b0, 16'hFF05, 16'h0003, 16'h8002, 1'b0, "R6 byte sub upper noise");
        // R5 shifts
        arith(3'd4, 1'b0, 16'h0, 16'h0, 16'h0040, 1'b1, "R5 shift carry out positive");
        arith(3'd4, 1'b0, 16'h0, 16'h0, 16'h0080, 1'b1, "R5 shift carry out negative");
        arith(3'd4, 1'b1, 16'h0, 16'h0, 16'h0000, 1'b0, "R5 word shift zero");
        arith(3'd4, 1'b1, 16'h0, 16'h0, 16'h8000, 1'b0, "R5 word shift negative no carry");
        // R8 whole load, R7 upper bits kept by arithmetic
        drive(1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, 8'h2A, 1'b0, 3'd0, 1'b0, "R8 whole load");
        arith(3'd1, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b0, "R7 add keeps upper bits");
        drive(1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, 8'hF0, 1'b0, 3'd0, 1'b0, "R8 load upper set");
        arith(3'd4, 1'b0, 16'h0, 16'h0, 16'h00C0, 1'b1, "R7 shift keeps upper bits");
        // R9 single flag
        drive(1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd6, 1'b0, "R9 clear bit 6");
        drive(1'b0, 3'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd1, 1'b1, "R9 set bit 1");
        drive(1'b1, 3'd1, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 3'd5, 1'b1,
              "R9 poke beats add");
        // R8 priority over everything
        drive(1'b1, 3'd2, 1'b1, 16'h0000, 16'h0001, 16'hFFFF, 1'b0, 1'b1, 8'h55, 1'b1, 3'd0, 1'b0,
              "R8 load beats poke and sub");
        // R10 no effect cases
        drive(1'b0, 3'd1, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0,
              "R10 operands without upd_en");
        arith(3'd0, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b0, "R10 op none");
        arith(3'd7, 1'b1, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, "R10 unused op 7");
        arith(3'd5, 1'b0, 16'h0080, 16'h0080, 16'h0000, 1'b1, "R10 unused op 5");
        idle("R10 idle hold");

        // R1 reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        n_vec++;
        if (ccr !== 8'hD0) begin
            n_bad++;
            $display("FAIL R1 second reset: ccr=%02h expected=d0", ccr);
        end
        rst_n = 1'b1;
        mdl = 8'hD0;
        idle("R1 after second release");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule